// File: doc/BRIEF.md
# Han-Carlson Parallel-Prefix Adder

This block is a purely combinational binary adder for operands whose width is a power of two (32 bits by default). It adds two unsigned operands and a carry input and returns the sum word and the carry out of the top bit. Callers that need a registered result place flops around it.

The work happens in three steps. The first forms a generate and a propagate term for every bit. The second merges those terms into group generate values with valency-2 combine cells. The third XORs each bit's propagate term with the carry into that bit.

The carry input enters the prefix network as an extra generate position below bit 0, so every complete group value is also the carry into the next bit. The prefix network uses the Han-Carlson arrangement. Odd bit positions are resolved by a logarithmic tree in which each stage doubles the span. After that tree, a single extra stage derives each even-position carry from its odd neighbour one place below.

Top module: `hc_adder`

## Requirements
- R1: For any operands and carry input, {cout, sum} equals a + b + cin taken as a (WIDTH+1)-bit unsigned value.
- R2: When a and b differ in every bit (a ^ b all ones), every sum bit equals the inverse of cin and cout equals cin.
- R3: When a and b are both all ones, sum is all ones except bit 0, which equals cin, and cout is 1.
- R4: When a and b are both zero, sum equals cin in bit 0 and zero in all other bits, and cout is 0.
- R5: A carry generated at any bit k, whether k is odd or even, travels through a run of propagate bits above it. With cin = 0, a holding ones in bits k through WIDTH-1 and b holding a single one at bit k gives a sum of zero and a cout of 1. Inside the prefix network, every odd bit's group spans down to the carry input by the end of the logarithmic tree.
- R6: The carry into each bit i above 0 equals g(i-1) | (p(i-1) & carry(i-1)), where g = a & b and p = a ^ b. As a result, setting a = b = (1 << k) with cin = 0 gives exactly bit k+1 set in the sum, or cout = 1 when k is the top bit.
- R7: The adder is built from the WIDTH parameter alone and satisfies R1 to R6 at widths 8, 16 and 32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First addend |
| b | input | WIDTH | Second addend |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of a + b + cin |
| cout | output | 1 | Carry out of bit WIDTH-1 |

## Verification
The embedded checks are immediate and evaluated on settled combinational values. They assume the operands and carry input are stable between changes and hold only known logic levels. The stimulus respects this by changing inputs only once per clock period, away from the clock edge, and by comparing the outputs a fixed delay later. Operand patterns include random words, all-propagate pairs built from a random word and its complement, all-generate and all-zero pairs, and single-bit generate sources swept across every even and odd position. These patterns deliberately push carries through the odd-position tree and the even-position completion stage over their full length.

// File: rtl/hc_pkg.sv
package hc_pkg;

    // generate/propagate pair for one bit or one group of bits
    typedef struct packed {
        logic g;
        logic p;
    } pg_t;

    // valency-2 merge: hi is the more significant group
    function automatic pg_t pg_merge(input pg_t hi, input pg_t lo);
        pg_t r;
        r.g = hi.g | (hi.p & lo.g);
        r.p = hi.p & lo.p;
        return r;
    endfunction

endpackage

// File: rtl/hc_bitpg.sv
module hc_bitpg #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]        a,
    input  logic [WIDTH-1:0]        b,
    input  logic                    cin,
    output hc_pkg::pg_t [WIDTH:0]   base
);
    // position 0 is the carry input, position j>0 is bit j-1
    assign base[0].g = cin;
    assign base[0].p = 1'b0;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign base[i+1].g = a[i] & b[i];
        assign base[i+1].p = a[i] ^ b[i];
    end
endmodule

// File: rtl/hc_combine.sv
module hc_combine (
    input  hc_pkg::pg_t hi,
    input  hc_pkg::pg_t lo,
    output hc_pkg::pg_t y
);
    assign y = hc_pkg::pg_merge(hi, lo);
endmodule

// File: rtl/hc_prefix.sv
module hc_prefix #(
    parameter int WIDTH = 32
) (
    input  hc_pkg::pg_t [WIDTH:0] base,
    output hc_pkg::pg_t [WIDTH:0] done
);
    import hc_pkg::*;

    localparam int LOG2W   = $clog2(WIDTH);
    localparam int TREE_LV = LOG2W + 1;   // last level of the odd-bit tree
    localparam int LAST_LV = LOG2W + 2;   // even completion level

    pg_t [WIDTH:0] lvl [0:LAST_LV];

    assign lvl[0] = base;

    // Odd bits live at even positions j >= 2. Level t merges with the
    // node D = 2^(t-1) positions below, while that node exists.
    for (genvar t = 1; t <= TREE_LV; t++) begin : g_tree
        localparam int D = 1 << (t - 1);
        for (genvar j = 0; j <= WIDTH; j++) begin : g_pos
            if ((j % 2 == 0) && (j >= 2) && (j - D >= 0)) begin : g_cell
                hc_combine u_cell (
                    .hi (lvl[t-1][j]),
                    .lo (lvl[t-1][j-D]),
                    .y  (lvl[t][j])
                );
            end else begin : g_pass
                assign lvl[t][j] = lvl[t-1][j];
            end
        end
    end

    // Even bits (odd positions) take their odd neighbour one place below.
    for (genvar j = 0; j <= WIDTH; j++) begin : g_even
        if (j % 2 == 1) begin : g_cell
            hc_combine u_cell (
                .hi (lvl[TREE_LV][j]),
                .lo (lvl[TREE_LV][j-1]),
                .y  (lvl[LAST_LV][j])
            );
        end else begin : g_pass
            assign lvl[LAST_LV][j] = lvl[TREE_LV][j];
        end
    end

    assign done = lvl[LAST_LV];

    always_comb begin
        for (int j = 2; j <= WIDTH; j += 2) begin
            AST_ODD_DONE_IN_TREE: assert (lvl[TREE_LV][j].p == 1'b0)
                else $error("odd-bit group at position %0d not closed by tree", j); // R5
        end
        for (int j = 0; j <= WIDTH; j++) begin
            AST_SPAN_REACHES_CIN: assert (lvl[LAST_LV][j].p == 1'b0)
                else $error("group at position %0d does not reach carry input", j); // R6
        end
        for (int j = 1; j <= WIDTH; j++) begin
            AST_RIPPLE_AGREES: assert (lvl[LAST_LV][j].g ==
                    (base[j].g | (base[j].p & lvl[LAST_LV][j-1].g)))
                else $error("prefix carry at position %0d breaks ripple rule", j); // R6
        end
    end
endmodule

// File: rtl/hc_sumxor.sv
module hc_sumxor #(
    parameter int WIDTH = 32
) (
    input  hc_pkg::pg_t [WIDTH:0] base,
    input  hc_pkg::pg_t [WIDTH:0] done,
    output logic [WIDTH-1:0]      sum,
    output logic                  cout
);
    // carry into bit i is the group generate at position i
    for (genvar i = 0; i < WIDTH; i++) begin : g_sum
        assign sum[i] = base[i+1].p ^ done[i].g;
    end
    assign cout = done[WIDTH].g;
endmodule

// File: rtl/hc_adder.sv
module hc_adder #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    import hc_pkg::*;

    pg_t [WIDTH:0] base;
    pg_t [WIDTH:0] done;

    hc_bitpg #(.WIDTH(WIDTH)) u_bitpg (
        .a    (a),
        .b    (b),
        .cin  (cin),
        .base (base)
    );

    hc_prefix #(.WIDTH(WIDTH)) u_prefix (
        .base (base),
        .done (done)
    );

    hc_sumxor #(.WIDTH(WIDTH)) u_sumxor (
        .base (base),
        .done (done),
        .sum  (sum),
        .cout (cout)
    );

    logic [WIDTH:0] ref_total;
    always_comb ref_total = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};

    always_comb begin
        AST_SUM_MATCH: assert ({cout, sum} == ref_total)
            else $error("sum mismatch"); // R1
        if ((a ^ b) == {WIDTH{1'b1}}) begin
            AST_ALL_PROPAGATE: assert (cout == cin && sum == {WIDTH{~cin}})
                else $error("all-propagate result wrong"); // R2
        end
        if (a == {WIDTH{1'b1}} && b == {WIDTH{1'b1}}) begin
            AST_ALL_GENERATE: assert (cout && sum[WIDTH-1:1] == {(WIDTH-1){1'b1}} && sum[0] == cin)
                else $error("all-generate result wrong"); // R3
        end
        if (a == '0 && b == '0) begin
            AST_ZERO_OPERANDS: assert (!cout && sum[WIDTH-1:1] == '0 && sum[0] == cin)
                else $error("zero-operand result wrong"); // R4
        end
    end
endmodule

// File: tb/test_hc_adder.sv
module test_hc_adder;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic [31:0] op_a, op_b;
    logic        c_in;
    logic [7:0]  s8;  logic co8;
    logic [15:0] s16; logic co16;
    logic [31:0] s32; logic co32;

    hc_adder #(.WIDTH(32)) i_hc_adder (
        .a(op_a), .b(op_b), .cin(c_in), .sum(s32), .cout(co32));
    hc_adder #(.WIDTH(16)) i_hc_adder_w16 (
        .a(op_a[15:0]), .b(op_b[15:0]), .cin(c_in), .sum(s16), .cout(co16));
    hc_adder #(.WIDTH(8)) i_hc_adder_w8 (
        .a(op_a[7:0]), .b(op_b[7:0]), .cin(c_in), .sum(s8), .cout(co8));

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] b;
        logic        cin;
        logic [32:0] exp;
    } vec_t;

    localparam int NTAB = 12;
    localparam vec_t TABLE [NTAB] = '{
        '{32'h0000_0000, 32'h0000_0000, 1'b0, 33'h0_0000_0000},   // R4
        '{32'h0000_0000, 32'h0000_0000, 1'b1, 33'h0_0000_0001},   // R4
        '{32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 33'h1_0000_0000},   // R2
        '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 33'h1_FFFF_FFFE},   // R3
        '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 33'h1_FFFF_FFFF},   // R3
        '{32'hAAAA_AAAA, 32'h5555_5555, 1'b0, 33'h0_FFFF_FFFF},   // R2
        '{32'hAAAA_AAAA, 32'h5555_5555, 1'b1, 33'h1_0000_0000},   // R2
        '{32'h1234_5678, 32'h8765_4321, 1'b0, 33'h0_9999_9999},   // R1
        '{32'h8000_0000, 32'h8000_0000, 1'b0, 33'h1_0000_0000},   // R6
        '{32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 33'h0_8000_0000},   // R5
        '{32'h0000_FFFF, 32'h0000_0001, 1'b0, 33'h0_0001_0000},   // R5
        '{32'hDEAD_BEEF, 32'h0000_0001, 1'b1, 33'h0_DEAD_BEF1}    // R1
    };

    function automatic logic [63:0] wmask(input int w);
        return (64'd1 << w) - 64'd1;
    endfunction

    task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic ci);
        @(negedge clk);
        op_a = a;
        op_b = b;
        c_in = ci;
        #1;
    endtask

    function automatic logic [63:0] result(input int w);
        if (w == 8)       return {55'd0, co8, s8};
        else if (w == 16) return {47'd0, co16, s16};
        else              return {31'd0, co32, s32};
    endfunction

    task automatic compare(input string req, input int w,
                           input logic [63:0] got, input logic [63:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s width %0d a=%h b=%h cin=%0d got=%h expected=%h",
                     req, w, op_a, op_b, c_in, got, exp);
        end
    endtask

    // expected value straight from R1
    task automatic apply(input string req, input int w, input logic [31:0] a,
                         input logic [31:0] b, input logic ci);
        logic [63:0] exp;
        drive(a, b, ci);
        exp = ({32'd0, a} & wmask(w)) + ({32'd0, b} & wmask(w)) + {63'd0, ci};
        compare(req, w, result(w), exp);
    endtask

    initial begin
        op_a = '0; op_b = '0; c_in = 1'b0;
        repeat (3) @(posedge clk);

        // idle state: all inputs zero gives zero outputs (R4)
        drive(32'd0, 32'd0, 1'b0);
        compare("R4 idle", 32, result(32), 64'd0);

        // table walk on the 32-bit instance (R1..R6)
        for (int i = 0; i < NTAB; i++) begin
            drive(TABLE[i].a, TABLE[i].b, TABLE[i].cin);
            compare("R1 table", 32, result(32), {31'd0, TABLE[i].exp});
        end

        for (int wi = 0; wi < 3; wi++) begin
            int w;
            logic [31:0] m;
            w = (wi == 0) ? 8 : (wi == 1) ? 16 : 32;   // R7
            m = wmask(w)[31:0];

            // R1 random operands
            for (int i = 0; i < 300; i++)
                apply("R1 R7 random", w, $urandom, $urandom, 1'($urandom));

            // R2 all-propagate: sum all ~cin, cout = cin
            for (int i = 0; i < 20; i++) begin
                logic [31:0] r;
                logic ci;
                r = $urandom;
                ci = 1'(i);
                drive(r, ~r, ci);
                compare("R2 all-propagate", w, result(w),
                        ({63'd0, ci} << w) | (ci ? 64'd0 : wmask(w)));
            end

            // R3 all-generate
            for (int ci = 0; ci < 2; ci++) begin
                drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'(ci));
                compare("R3 all-generate", w, result(w),
                        (64'd1 << w) | (wmask(w) & ~64'd1) | 64'(ci));
            end

            // R4 zero operands
            for (int ci = 0; ci < 2; ci++) begin
                drive(32'd0, 32'd0, 1'(ci));
                compare("R4 zero operands", w, result(w), 64'(ci));
            end

            // R5 generate at bit k rides a propagate run to cout
            for (int k = 0; k < w; k++) begin
                drive(m & ~((32'd1 << k) - 32'd1), 32'd1 << k, 1'b0);
                compare("R5 carry run", w, result(w), 64'd1 << w);
            end

            // R6 isolated generate at bit k sets only bit k+1
            for (int k = 0; k < w; k++) begin
                drive(32'd1 << k, 32'd1 << k, 1'b0);
                compare("R6 isolated generate", w, result(w), 64'd1 << (k + 1));
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        finished = 1'b1;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired got=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule